// File: doc/BRIEF.md
# Defect-Skipping Readout Address Sequencer

This block produces the row and column addresses that walk an image array during readout, one address per clock. Four programmable entries describe defective lines. Each entry marks one row or one column as bad. A row that holds even a single bad pixel is handled by marking the whole row, so one entry is enough for it.

While a frame is scanned, the current row address and the current column address are each compared against every valid entry at the same time. A row match makes the sequencer leave that row after one cycle. A column match suppresses the pixel strobe for that one address, and the count moves on to the next column. The pixel-valid strobe is therefore high only on addresses that belong to a good row and a good column. When the last row has been handled, the block returns to idle and pulses frame-done for one cycle.

The table is loaded through a simple write port while no frame is running. A frame is started by a one-cycle start request.

Top module: `dskip_seq`

## Requirements
- R1: After synchronous reset the block is idle: busy, pix_valid and frame_done are 0, and row_addr and col_addr are 0.
- R2: The table has four entries, selected by wr_idx (0 to 3). Each entry holds a valid bit, a kind bit (0 = row, 1 = column) and a 10-bit address. A write with wr_en high while busy is 0 replaces the selected entry at that clock edge. A written entry then governs every later frame.
- R3: A write presented while busy is 1 is discarded. Neither the current frame nor any later frame changes because of it.
- R4: When start is high while the block is idle, busy is 1 from the next cycle, with row_addr = 0 and col_addr = 0. Inside a good row, col_addr rises by 1 each cycle, from 0 to COLS-1.
- R5: An entry whose valid bit is 0 never matches any address.
- R6: When row_addr equals the address of a valid row-kind entry, that row takes exactly one cycle, with pix_valid 0 and col_addr 0. The next cycle presents the next row at column 0. Several adjacent bad rows each take one such cycle.
- R7: When col_addr equals the address of a valid column-kind entry, pix_valid is 0 for that single cycle and the column count continues with the next column. This includes columns 0 and COLS-1 and adjacent bad columns.
- R8: During a frame, pix_valid is 1 exactly on the cycles where neither the current row nor the current column is flagged. A good row takes COLS cycles, so one frame is busy for (good rows × COLS + bad rows) cycles.
- R9: After the last row (ROWS-1) the block returns to idle. busy falls, and in that same cycle frame_done is 1 for exactly one cycle. Rows and columns then read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame when idle |
| wr_en | input | 1 | Table write request |
| wr_idx | input | 2 | Entry selected for writing |
| wr_valid | input | 1 | Valid bit of the written entry |
| wr_is_col | input | 1 | Kind of the written entry: 0 row, 1 column |
| wr_addr | input | 10 | Defective row or column address |
| busy | output | 1 | A frame is being scanned |
| row_addr | output | 10 | Current row address |
| col_addr | output | 10 | Current column address |
| pix_valid | output | 1 | Current address is a good pixel |
| frame_done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The bench builds the sequencer with ROWS = 6 and COLS = 5, while keeping the full 10-bit address width. With an array this small, a whole frame lasts only a few dozen cycles. This puts within reach the first and last rows, the edge columns 0 and 4, runs of adjacent bad rows that reach the final row wrap, and a table whose four entries are all row entries. Every cycle of each frame is compared against an address walk derived from the requirements.

// File: rtl/dskip_pkg.sv
package dskip_pkg;

    parameter int ADDR_W = 10;
    parameter int N_ENT  = 4;
    parameter int IDX_W  = $clog2(N_ENT);

    typedef enum logic {
        KIND_ROW = 1'b0,
        KIND_COL = 1'b1
    } kind_e;

    typedef struct packed {
        logic              valid;
        kind_e             kind;
        logic [ADDR_W-1:0] addr;
    } entry_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } seq_state_e;

    function automatic entry_t make_entry(input logic v, input logic is_col,
                                          input logic [ADDR_W-1:0] a);
        entry_t e;
        e.valid = v;
        e.kind  = is_col ? KIND_COL : KIND_ROW;
        e.addr  = a;
        return e;
    endfunction

    function automatic logic entry_hits(input entry_t e, input kind_e k,
                                        input logic [ADDR_W-1:0] a);
        return e.valid && (e.kind == k) && (e.addr == a);
    endfunction

endpackage

// File: rtl/dskip_table.sv
module dskip_table
    import dskip_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  entry_t                 wr_data,
    output entry_t [N_ENT-1:0]     ents
);

    entry_t [N_ENT-1:0] ents_q;

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ents_q[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                ents_q[i] <= wr_data;
            end
        end
    end

    assign ents = ents_q;

endmodule

// File: rtl/dskip_match.sv
module dskip_match
    import dskip_pkg::*;
#(
    parameter kind_e KIND = KIND_ROW
) (
    input  entry_t [N_ENT-1:0]     ents,
    input  logic [ADDR_W-1:0]      addr,
    output logic                   hit
);

    logic [N_ENT-1:0] hit_vec;

    for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
        assign hit_vec[i] = entry_hits(ents[i], KIND, addr);
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/dskip_ctrl.sv
module dskip_ctrl
    import dskip_pkg::*;
#(
    parameter int ROWS = 1024,
    parameter int COLS = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              row_hit,
    input  logic              col_hit,
    output logic              busy,
    output logic [ADDR_W-1:0] row_q,
    output logic [ADDR_W-1:0] col_q,
    output logic              pix_valid,
    output logic              frame_done
);

    localparam logic [ADDR_W-1:0] LAST_ROW = ADDR_W'(ROWS - 1);
    localparam logic [ADDR_W-1:0] LAST_COL = ADDR_W'(COLS - 1);

    seq_state_e state_q;
    logic       done_q;
    logic       row_end;

    assign row_end = row_hit || (col_q == LAST_COL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            row_q   <= '0;
            col_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_SCAN;
                        row_q   <= '0;
                        col_q   <= '0;
                    end
                end
                ST_SCAN: begin
                    if (row_end) begin
                        col_q <= '0;
                        if (row_q == LAST_ROW) begin
                            state_q <= ST_IDLE;
                            row_q   <= '0;
                            done_q  <= 1'b1;
                        end else begin
                            row_q <= row_q + 1'b1;
                        end
                    end else begin
                        col_q <= col_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state_q == ST_SCAN);
    assign pix_valid  = busy && !row_hit && !col_hit;
    assign frame_done = done_q;

endmodule

// File: rtl/dskip_seq.sv
module dskip_seq
    import dskip_pkg::*;
#(
    parameter int ROWS = 1024,
    parameter int COLS = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr_en,
    input  logic [1:0]        wr_idx,
    input  logic              wr_valid,
    input  logic              wr_is_col,
    input  logic [9:0]        wr_addr,
    output logic              busy,
    output logic [9:0]        row_addr,
    output logic [9:0]        col_addr,
    output logic              pix_valid,
    output logic              frame_done
);

    entry_t [N_ENT-1:0] ents;
    logic               wr_take;
    logic               row_hit;
    logic               col_hit;

    assign wr_take = wr_en && !busy;

    dskip_table u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_take),
        .wr_idx  (IDX_W'(wr_idx)),
        .wr_data (make_entry(wr_valid, wr_is_col, ADDR_W'(wr_addr))),
        .ents    (ents)
    );

    dskip_match #(.KIND(KIND_ROW)) u_row_match (
        .ents (ents),
        .addr (row_addr),
        .hit  (row_hit)
    );

    dskip_match #(.KIND(KIND_COL)) u_col_match (
        .ents (ents),
        .addr (col_addr),
        .hit  (col_hit)
    );

    dskip_ctrl #(.ROWS(ROWS), .COLS(COLS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .row_hit    (row_hit),
        .col_hit    (col_hit),
        .busy       (busy),
        .row_q      (row_addr),
        .col_q      (col_addr),
        .pix_valid  (pix_valid),
        .frame_done (frame_done)
    );

endmodule

// File: rtl/dskip_seq_chk.sv
module dskip_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic [9:0] row_addr,
    input logic [9:0] col_addr,
    input logic       pix_valid,
    input logic       frame_done,
    input logic       row_hit,
    input logic       col_hit
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !pix_valid);

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    p_done_at_end_r9: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> $fell(busy));

    p_col_step_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && (row_addr == $past(row_addr)))
            |-> (col_addr == 10'($past(col_addr) + 10'd1)));

    p_row_leave_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && row_hit) |=> (!busy || (col_addr == 10'd0 &&
                                row_addr == 10'($past(row_addr) + 10'd1))));

    p_col_skip_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && col_hit) |-> !pix_valid);

endmodule

bind dskip_seq dskip_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .row_addr   (row_addr),
    .col_addr   (col_addr),
    .pix_valid  (pix_valid),
    .frame_done (frame_done),
    .row_hit    (row_hit),
    .col_hit    (col_hit)
);

// File: tb/dskip_seq_bench.sv
module dskip_seq_bench;

    localparam int ROWS = 6;
    localparam int COLS = 5;

    typedef struct packed {
        logic [3:0][11:0] ents;
        logic [7:0]       exp_pix;
        logic [7:0]       exp_cyc;
    } vec_t;

    function automatic logic [11:0] ent(input logic v, input logic c, input int a);
        return {v, c, 10'(a)};
    endfunction

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{ents: {ent(0,0,0), ent(0,0,0), ent(0,0,0), ent(0,0,0)}, exp_pix: 8'd30, exp_cyc: 8'd30},
        '{ents: {ent(0,0,0), ent(0,0,0), ent(0,0,0), ent(1,0,2)}, exp_pix: 8'd25, exp_cyc: 8'd26},
        '{ents: {ent(0,0,0), ent(0,0,0), ent(1,1,4), ent(1,1,0)}, exp_pix: 8'd18, exp_cyc: 8'd30},
        '{ents: {ent(0,0,0), ent(1,1,1), ent(1,0,5), ent(1,0,4)}, exp_pix: 8'd16, exp_cyc: 8'd22},
        '{ents: {ent(0,1,2), ent(0,0,3), ent(0,0,1), ent(1,0,0)}, exp_pix: 8'd25, exp_cyc: 8'd26},
        '{ents: {ent(1,0,3), ent(1,0,2), ent(1,0,1), ent(1,0,0)}, exp_pix: 8'd10, exp_cyc: 8'd14}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_idx = '0;
    logic       wr_valid = 1'b0;
    logic       wr_is_col = 1'b0;
    logic [9:0] wr_addr = '0;
    logic       busy;
    logic [9:0] row_addr;
    logic [9:0] col_addr;
    logic       pix_valid;
    logic       frame_done;

    int total = 0;
    int bad = 0;
    logic [3:0][11:0] model_tab;

    always #2.5 clk = ~clk;

    dskip_seq #(.ROWS(ROWS), .COLS(COLS)) u_dskip_seq (
        .clk(clk), .rst(rst), .start(start), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_valid(wr_valid), .wr_is_col(wr_is_col), .wr_addr(wr_addr),
        .busy(busy), .row_addr(row_addr), .col_addr(col_addr),
        .pix_valid(pix_valid), .frame_done(frame_done)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic flagged(input logic is_col, input int a);
        for (int i = 0; i < 4; i++)
            if (model_tab[i][11] && model_tab[i][10] == is_col && int'(model_tab[i][9:0]) == a)
                return 1'b1;
        return 1'b0;
    endfunction

    task automatic write_ent(input int idx, input logic [11:0] e);
        wr_en = 1'b1; wr_idx = 2'(idx);
        wr_valid = e[11]; wr_is_col = e[10]; wr_addr = e[9:0];
        tick();
        wr_en = 1'b0;
    endtask

    task automatic load_table(input logic [3:0][11:0] t);
        for (int i = 0; i < 4; i++) write_ent(i, t[i]);
        model_tab = t;
    endtask

    // Runs one frame; optional write injected while busy (R3).
    task automatic run_frame(input string tag, input int exp_pix, input int exp_cyc,
                             input logic inject);
        int er = 0;
        int ec = 0;
        int pix = 0;
        int cyc = 0;
        int walk_err = 0;
        start = 1'b1;
        tick();
        start = 1'b0;
        while (busy && cyc < 2000) begin
            if (int'(row_addr) != er || int'(col_addr) != ec) walk_err++;
            if (pix_valid != (!flagged(1'b0, er) && !flagged(1'b1, ec))) walk_err++;
            if (pix_valid) pix++;
            cyc++;
            if (inject && cyc == 3) begin
                wr_en = 1'b1; wr_idx = 2'd0; wr_valid = 1'b1;
                wr_is_col = 1'b0; wr_addr = 10'd1;
            end
            if (flagged(1'b0, er) || ec == COLS - 1) begin
                ec = 0; er++;
            end else begin
                ec++;
            end
            tick();
            wr_en = 1'b0;
        end
        check(walk_err == 0, {"R4/R6/R7 walk ", tag}, walk_err, 0);
        check(pix == exp_pix, {"R8 pixel count ", tag}, pix, exp_pix);
        check(cyc == exp_cyc, {"R8 busy cycles ", tag}, cyc, exp_cyc);
        check(frame_done == 1'b1, {"R9 done pulse ", tag}, int'(frame_done), 1);
        check(row_addr == 0 && col_addr == 0, {"R9 idle address ", tag},
              int'(row_addr) + int'(col_addr), 0);
        tick();
        check(frame_done == 1'b0, {"R9 done one cycle ", tag}, int'(frame_done), 0);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        check(!busy && !pix_valid && !frame_done && row_addr == 0 && col_addr == 0,
              "R1 reset state", int'(busy) + int'(pix_valid) + int'(frame_done), 0);

        for (int v = 0; v < NV; v++) begin
            load_table(VECS[v].ents);
            run_frame($sformatf("vec%0d R2 R5", v), int'(VECS[v].exp_pix),
                      int'(VECS[v].exp_cyc), 1'b0);
        end

        // R3: write during a frame is dropped, this frame and the next.
        load_table({ent(0,0,0), ent(0,0,0), ent(0,0,0), ent(0,0,0)});
        run_frame("R3 during", 30, 30, 1'b1);
        run_frame("R3 after", 30, 30, 1'b0);

        // R1: reset mid-frame returns to idle.
        start = 1'b1; tick(); start = 1'b0;
        repeat (4) tick();
        rst = 1'b1; tick(); rst = 1'b0;
        check(!busy && !pix_valid && row_addr == 0 && col_addr == 0,
              "R1 reset mid-frame", int'(busy) + int'(row_addr), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule